// File: doc/BRIEF.md
# Nibble-Multiplexed Calendar Clock Interface

This block keeps wall-clock time and calendar date as packed BCD digits: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A one-cycle `tick_sec` pulse advances the time by one second. Each carry ripples through the fields, and the month length comes from a small table with a simple divisible-by-four leap rule.

Software reaches the clock through two byte registers. A command register at offset 10 picks one of thirteen digit positions and holds three control flags: freeze, digit-write enable and a read flag that is stored but has no effect. A data register at offset 11 returns the selected digit, and it loads that digit when digit-write is enabled. While the freeze flag is set, the counters stand still, so a multi-digit read stays coherent. One missed second is owed and is applied after the freeze ends.

A four-state machine in the control unit handles the owed second. `RUN` is normal counting. `HOLD` means frozen with nothing owed. `HOLD_PEND` means frozen with one second owed. `CATCHUP` means free-running with one second still owed. The transitions are:

- `RUN`/`HOLD` to `HOLD` when freeze is set and no tick arrives.
- `RUN`/`HOLD` to `HOLD_PEND` when freeze is set and a tick arrives.
- `HOLD`/`HOLD_PEND`/`CATCHUP` to `RUN` when freeze is clear and nothing more is owed.
- `HOLD_PEND` to `CATCHUP` on release when a digit write or a fresh tick defers the owed second.
- `CATCHUP` to `HOLD_PEND` when freeze is set again.
- `RUN` to `CATCHUP` when a tick coincides with a digit write.

Top module: `rtc_nibble_if`

## Requirements
- R1: Only offsets 10 (command) and 11 (data) are decoded. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R2: A command write stores the digit index from data bits 3:0 and the flags from bits 7:4. Bit 6 is freeze, bit 5 is digit-write and bit 4 is the read flag, which is stored but has no effect.
- R3: A read of the command register returns 0xFF.
- R4: A data read returns the selected digit in bits 3:0 with bits 7:4 zero. The digit indices are: 0/1 seconds units/tens, 2/3 minutes units/tens, 4/5 hours units/tens, 6 day of week, 7/8 day units/tens, 9/10 month units/tens, 11/12 year units/tens.
- R5: Digit 5 reads as bits 1:0 = hours tens, bit 2 = 0 and bit 3 = 1, which marks 24-hour format.
- R6: Digit indices 13 to 15 read as 0x00.
- R7: After reset the time is 00:00:00, day of week 0, day 01, month 01, year 00, and the command register is zero.
- R8: Each tick adds one second. Seconds and minutes wrap at 59, and hours wrap at 23. A day rollover advances the day of week, which wraps from 6 to 0.
- R9: Day of month wraps to 01 after the month length: 30 for months 4, 6, 9 and 11; 31 for the other months except February; for February, 29 when the year is divisible by 4 and 28 otherwise. Month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R10: While freeze is set, no digit changes on a tick. Any number of ticks during a freeze adds exactly one second, one cycle after release.
- R11: A data write loads the selected digit only when digit-write is set. Digit 5 keeps only 2 bits. Without the flag, a data write has no effect.
- R12: A tick that coincides with a digit write is not lost. It is applied on the following cycle, after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when bus_rd is low |

## Verification
The counting function is tried with a table of preset dates, each followed by one or more ticks. The presets are a plain seconds step, minute and hour carries, and an hour-units-to-tens carry. Month-end rollovers cover 30-day, 31-day, leap and non-leap February, and leap years with both even and odd tens digits. A year-end wrap and a 61-tick run complete the table. A wrong month-length entry, a broken leap decode or a dropped carry shows up in a different digit in each case. Directed tests then separate the freeze paths (several ticks collapsing to one owed second) from a tick coinciding with a digit write, and check decode, index-range and flag-gating behaviour.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NIB_W      = 4;
    localparam int NUM_DIGITS = 13;
    localparam int SEL_W      = 4;

    localparam int IDX_HR_T   = 5;
    localparam int IDX_DOW    = 6;

    localparam int FLG_HOLD   = 2;
    localparam int FLG_WRITE  = 1;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HOLD,
        ST_HOLD_PEND,
        ST_CATCHUP
    } rtc_state_e;

    // Step a two-digit BCD value; bit 8 is the carry out of the field.
    function automatic logic [8:0] bcd_step(input logic [7:0] cur,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (cur == last)
            return {1'b1, first};
        else if (cur[3:0] == 4'd9)
            return {1'b0, cur[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, cur[7:4], cur[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0)
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon,
                                            input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CMD_OFS  = 10,
    parameter int DATA_OFS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [SEL_W-1:0]  sel,
    output logic              dig_wr,
    output logic              adv
);

    localparam int FLAG_W = DATA_W - SEL_W;

    logic [FLAG_W-1:0] flags_q;
    logic [SEL_W-1:0]  sel_q;
    logic              hold_q;
    logic              cmd_wr;
    rtc_state_e        state_q, state_d;
    logic              unused_flags;

    assign cmd_wr       = bus_wr && (bus_addr == ADDR_W'(CMD_OFS));
    assign hold_q       = flags_q[FLG_HOLD];
    assign sel          = sel_q;
    assign dig_wr       = bus_wr && (bus_addr == ADDR_W'(DATA_OFS)) && flags_q[FLG_WRITE];
    assign unused_flags = ^{flags_q[FLAG_W-1], flags_q[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            sel_q   <= '0;
        end else if (cmd_wr) begin
            flags_q <= bus_wdata[DATA_W-1:SEL_W];
            sel_q   <= bus_wdata[SEL_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_HOLD: begin
                if (hold_q)
                    state_d = tick_sec ? ST_HOLD_PEND : ST_HOLD;
                else if (tick_sec && dig_wr)
                    state_d = ST_CATCHUP;
                else
                    state_d = ST_RUN;
            end
            ST_HOLD_PEND: begin
                if (hold_q)
                    state_d = ST_HOLD_PEND;
                else if (dig_wr || tick_sec)
                    state_d = ST_CATCHUP;
                else
                    state_d = ST_RUN;
            end
            ST_CATCHUP: begin
                if (hold_q)
                    state_d = ST_HOLD_PEND;
                else if (dig_wr || tick_sec)
                    state_d = ST_CATCHUP;
                else
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_RUN, ST_HOLD:           adv = !hold_q && tick_sec && !dig_wr;
            ST_HOLD_PEND, ST_CATCHUP:  adv = !hold_q && !dig_wr;
            default:                   adv = 1'b0;
        endcase
    end

    AST_NO_ADV_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !adv); // R10
    AST_OWED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_PEND && !hold_q && !dig_wr) |-> adv); // R10
    AST_WRITE_BLOCKS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        dig_wr |-> !adv); // R12
    AST_DEFERRED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sec && dig_wr && !hold_q) |=> (state_q == ST_CATCHUP)); // R12

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               adv,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_idx,
    input  logic [NIB_W-1:0]                   wr_nib,
    output logic [NUM_DIGITS-1:0][NIB_W-1:0]   digits
);

    localparam logic [NUM_DIGITS*NIB_W-1:0] RESET_TIME = 52'h0001010000000;

    logic [NUM_DIGITS-1:0][NIB_W-1:0] dig_q, dig_nxt;
    logic [8:0] st_sec, st_min, st_hr, st_day, st_mon, st_yr;
    logic [7:0] mlen;

    assign digits = dig_q;
    assign mlen   = last_day(dig_q[10:9], dig_q[12:11]);

    always_comb begin
        st_sec  = bcd_step(dig_q[1:0],   8'h59, 8'h00);
        st_min  = bcd_step(dig_q[3:2],   8'h59, 8'h00);
        st_hr   = bcd_step(dig_q[5:4],   8'h23, 8'h00);
        st_day  = bcd_step(dig_q[8:7],   mlen,  8'h01);
        st_mon  = bcd_step(dig_q[10:9],  8'h12, 8'h01);
        st_yr   = bcd_step(dig_q[12:11], 8'h99, 8'h00);
        dig_nxt = dig_q;
        dig_nxt[1:0] = st_sec[7:0];
        if (st_sec[8]) begin
            dig_nxt[3:2] = st_min[7:0];
            if (st_min[8]) begin
                dig_nxt[5:4] = st_hr[7:0];
                if (st_hr[8]) begin
                    dig_nxt[IDX_DOW] = (dig_q[IDX_DOW] == 4'd6) ? 4'd0 : dig_q[IDX_DOW] + 4'd1;
                    dig_nxt[8:7]     = st_day[7:0];
                    if (st_day[8]) begin
                        dig_nxt[10:9] = st_mon[7:0];
                        if (st_mon[8])
                            dig_nxt[12:11] = st_yr[7:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q <= RESET_TIME;
        end else if (wr_en) begin
            if (wr_idx == SEL_W'(IDX_HR_T))
                dig_q[wr_idx] <= {2'b00, wr_nib[1:0]};
            else if (wr_idx < SEL_W'(NUM_DIGITS))
                dig_q[wr_idx] <= wr_nib;
        end else if (adv) begin
            dig_q <= dig_nxt;
        end
    end

    AST_FROZEN_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> $stable(dig_q)); // R10
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && dig_q[1:0] == 8'h59) |=> (dig_q[1:0] == 8'h00)); // R8
    AST_HR_TENS_2BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == SEL_W'(IDX_HR_T)) |=> (dig_q[IDX_HR_T][3:2] == 2'b00)); // R11

endmodule

// File: rtl/rtc_digit_mux.sv
module rtc_digit_mux
    import rtc_pkg::*;
(
    input  logic [NUM_DIGITS-1:0][NIB_W-1:0] digits,
    input  logic [SEL_W-1:0]                 sel,
    output logic [NIB_W-1:0]                 nib
);

    always_comb begin
        if (sel == SEL_W'(IDX_HR_T))
            nib = {1'b1, 1'b0, digits[IDX_HR_T][1:0]};
        else if (sel < SEL_W'(NUM_DIGITS))
            nib = digits[sel];
        else
            nib = '0;
    end

endmodule

// File: rtl/rtc_nibble_if.sv
module rtc_nibble_if
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CMD_OFS  = 10,
    parameter int DATA_OFS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [SEL_W-1:0]                 sel;
    logic                             dig_wr;
    logic                             adv;
    logic [NUM_DIGITS-1:0][NIB_W-1:0] digits;
    logic [NIB_W-1:0]                 nib;

    rtc_cmd_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CMD_OFS  (CMD_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sec  (tick_sec),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .sel       (sel),
        .dig_wr    (dig_wr),
        .adv       (adv)
    );

    rtc_time_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .wr_en  (dig_wr),
        .wr_idx (sel),
        .wr_nib (bus_wdata[NIB_W-1:0]),
        .digits (digits)
    );

    rtc_digit_mux u_mux (
        .digits (digits),
        .sel    (sel),
        .nib    (nib)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(CMD_OFS))
                bus_rdata = '1;
            else if (bus_addr == ADDR_W'(DATA_OFS))
                bus_rdata = {{(DATA_W-NIB_W){1'b0}}, nib};
        end
    end

    AST_CMD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(CMD_OFS)) |-> (bus_rdata == '1)); // R3
    AST_HIGH_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_OFS) && sel >= SEL_W'(NUM_DIGITS)) |-> (bus_rdata == '0)); // R6
    AST_HRS_FORMAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_OFS) && sel == SEL_W'(IDX_HR_T)) |-> (bus_rdata[3:2] == 2'b10)); // R5
    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_OFS)) |-> (bus_rdata[DATA_W-1:NIB_W] == '0)); // R4
    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(CMD_OFS) && bus_addr != ADDR_W'(DATA_OFS)) |-> (bus_rdata == '0)); // R1

endmodule

// File: tb/rtc_nibble_if_tb.sv
module rtc_nibble_if_tb;

    localparam logic [3:0] A_CMD  = 4'd10;
    localparam logic [3:0] A_DATA = 4'd11;

    // {start time (13 nibbles, digit 12 first), tick count, expected time}
    localparam int NV = 12;
    localparam logic [111:0] VEC [NV] = '{
        {52'h0010100000000, 8'd5,  52'h0010100000005},  // R8 plain seconds
        {52'h2306153123459, 8'd1,  52'h2306153123500},  // R8 minute carry
        {52'h2306306235959, 8'd1,  52'h2307010000000},  // R9 30-day month end, dow wrap
        {52'h9912315235959, 8'd1,  52'h0001016000000},  // R9 year wrap
        {52'h2302282235959, 8'd1,  52'h2303013000000},  // R9 non-leap Feb
        {52'h2402281235959, 8'd1,  52'h2402292000000},  // R9 leap Feb 28->29
        {52'h2402292235959, 8'd1,  52'h2403013000000},  // R9 leap Feb 29->Mar
        {52'h2304304235959, 8'd1,  52'h2305015000000},  // R9 April end
        {52'h2301301235959, 8'd1,  52'h2301312000000},  // R9 31-day month
        {52'h2301010095959, 8'd1,  52'h2301010100000},  // R8 hour units carry
        {52'h1202280235959, 8'd1,  52'h1202291000000},  // R9 leap with odd tens
        {52'h2301010000000, 8'd61, 52'h2301010000101}   // R8 long run
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rtc_nibble_if u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sec  (tick_sec),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_sec = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0;
    endtask

    task automatic read_digit(input int idx, output logic [7:0] d);
        wr(A_CMD, {4'h0, 4'(idx)});
        rd(A_DATA, d);
    endtask

    function automatic logic [7:0] shown(input int idx, input logic [3:0] raw);
        if (idx == 5) return {4'h0, 2'b10, raw[1:0]};
        return {4'h0, raw};
    endfunction

    task automatic load_time(input logic [51:0] t);
        for (int i = 0; i < 13; i++) begin
            wr(A_CMD, {4'h6, 4'(i)});
            wr(A_DATA, {4'h0, t[i*4 +: 4]});
        end
        wr(A_CMD, 8'h00);
    endtask

    task automatic check_all(input string req, input logic [51:0] t);
        logic [7:0] d;
        for (int i = 0; i < 13; i++) begin
            read_digit(i, d);
            check(req, d, shown(i, t[i*4 +: 4]));
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state; command register index 0 with no flags
        rd(A_DATA, d);
        check("R7 cmd reset idx0", d, 8'h00);
        check_all("R7 reset time", 52'h0001010000000);

        // R3 command read
        rd(A_CMD, d);
        check("R3 cmd read", d, 8'hFF);

        // R5 hours tens flag (hours 00)
        read_digit(5, d);
        check("R5 hrs tens flag", d, 8'h08);

        // R6 out-of-range indices
        read_digit(13, d);
        check("R6 idx13", d, 8'h00);
        read_digit(15, d);
        check("R6 idx15", d, 8'h00);

        // Table walk: R4 R8 R9 R2
        for (int v = 0; v < NV; v++) begin
            load_time(VEC[v][111:60]);
            for (int k = 0; k < int'(VEC[v][59:52]); k++) pulse_tick();
            check_all("R4 R8 R9 vector", VEC[v][51:0]);
        end

        // R10 freeze: three ticks held, one applied on release
        load_time(52'h2301010000000);
        wr(A_CMD, 8'h40);
        pulse_tick(); pulse_tick(); pulse_tick();
        rd(A_DATA, d);
        check("R10 frozen sec", d, 8'h00);
        wr(A_CMD, 8'h00);
        read_digit(0, d);
        check("R10 owed second", d, 8'h01);
        repeat (5) @(negedge clk);
        read_digit(0, d);
        check("R10 only one owed", d, 8'h01);

        // R12 tick coincides with digit write
        wr(A_CMD, 8'h22);
        @(negedge clk);
        bus_addr = A_DATA; bus_wdata = 8'h05; bus_wr = 1'b1; tick_sec = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_sec = 1'b0;
        read_digit(2, d);
        check("R12 written digit", d, 8'h05);
        read_digit(0, d);
        check("R12 deferred tick", d, 8'h02);

        // R11 data write without write flag is ignored
        wr(A_CMD, 8'h00);
        wr(A_DATA, 8'h09);
        read_digit(0, d);
        check("R11 no write flag", d, 8'h02);

        // R11 hours tens keeps two bits
        wr(A_CMD, 8'h25);
        wr(A_DATA, 8'h0E);
        read_digit(5, d);
        check("R11 hrs tens 2 bits", d, 8'h0A);

        // R1 undecoded offset: read zero, write has no effect
        rd(4'd3, d);
        check("R1 undecoded read", d, 8'h00);
        wr(A_CMD, 8'h00);
        wr(4'd3, 8'h2C);
        wr(A_DATA, 8'h07);
        read_digit(12, d);
        check("R1 undecoded write", d, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule